// File: doc/BRIEF.md
# Peripheral Bus Master

This block is a synchronous master for a simple, non-pipelined peripheral bus. Clients hand it read and write requests on a valid/ready request port. Each request carries a write flag, an address, write data and the index of the target slave. The master turns every accepted request into exactly one setup cycle followed by exactly one active (enable) cycle. It drives a one-hot per-slave select vector, an enable strobe, the write flag, the address and the write data. There are no wait states and no error responses.

At the clock edge that ends the active cycle, the master samples the read data bus. One cycle later it raises a single-cycle response pulse carrying that data, or a write-done indication. A new request can be accepted in the last (active) cycle of a transfer if it targets the slave that is already selected. The bus then goes straight back to setup with the select held, giving one transfer every two cycles. A request for a different slave waits: the bus first drops to idle for one cycle.

Top module: `pbm_master`

## Requirements
- R1: While reset is asserted, and after it is released with no request, bus_sel is all zero, bus_en is low, bus_write is low, bus_addr and bus_wdata are zero, rsp_valid is low and req_ready is high.
- R2: A request accepted in the idle state (req_valid and req_ready high at a rising edge) produces a setup cycle in the next cycle. In that cycle bus_sel has only bit req_slave set, bus_addr and bus_write equal the request, and bus_en is low.
- R3: The setup cycle lasts exactly one clock and is followed by exactly one active cycle with bus_en high. bus_en is never high for two consecutive cycles.
- R4: bus_sel, bus_addr and bus_write do not change from the setup cycle to the active cycle. For a write, bus_wdata equals the request's write data during the active cycle.
- R5: req_ready is high in the idle state. It is high in the active cycle only when req_slave equals the currently selected slave index. It is low in the setup cycle, and a request presented there has no effect on the bus.
- R6: For a read, the value on bus_rdata at the edge that ends the active cycle appears on rsp_rdata in the next cycle. In that cycle rsp_valid is high for exactly one cycle and rsp_write is low.
- R7: For a write, rsp_valid is high for exactly one cycle after the active cycle, with rsp_write high and rsp_rdata zero.
- R8: A same-slave request accepted during the active cycle is followed directly by a new setup cycle. In that cycle bus_sel stays asserted on the same bit and bus_addr shows the new address.
- R9: When no request is accepted in the active cycle, the next cycle is idle: bus_sel all zero, bus_en low, bus_addr and bus_wdata zero.
- R10: bus_sel never has more than one bit set, and bus_en is high only while a select bit is set.
- R11: A request for a different slave, presented during the active cycle, is not accepted there. The bus spends one idle cycle, and the request is then accepted and produces a setup cycle with the new select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (8) | Target address |
| req_wdata | input | DW (8) | Data for a write |
| req_slave | input | $clog2(NUM_SLV) (2) | Index of the target slave |
| bus_sel | output | NUM_SLV (4) | One-hot slave select |
| bus_en | output | 1 | Enable strobe, high in the active cycle |
| bus_write | output | 1 | Bus write flag |
| bus_addr | output | AW (8) | Bus address |
| bus_wdata | output | DW (8) | Bus write data |
| bus_rdata | input | DW (8) | Read data from the selected slave |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_write | output | 1 | Completed transfer was a write |
| rsp_rdata | output | DW (8) | Read data of a completed read |

## Verification
The phase register is the bus state itself, because the select-any and enable bits are its two bits. A corrupted phase therefore shows on bus_sel and bus_en in the same cycle, for example an enable with no select, two enable cycles in a row, or a setup that never reaches enable. A wrong request register shows on the bus one cycle after acceptance, as a wrong select bit or address, or as an address that moves between setup and active. A wrong chaining decision shows on req_ready during the active cycle and as a missing or extra idle cycle on bus_sel right after it. Response faults show one cycle after the active cycle, as a missing, doubled or wrong-valued rsp_valid pulse.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  // Phase encoding is {select_any, enable}, so the register mirrors the bus.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_SETUP  = 2'b10,
    PH_ACTIVE = 2'b11
  } phase_e;

endpackage

// File: rtl/pbm_fsm.sv
module pbm_fsm
  import pbm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   same_slave,
  output phase_e phase,
  output logic   req_ready,
  output logic   accept,
  output logic   finish
);

  phase_e phase_q;
  phase_e phase_d;

  // Ready: free bus, or last cycle of a transfer to the same slave.
  always_comb begin
    req_ready = 1'b0;
    unique case (phase_q)
      PH_IDLE:   req_ready = 1'b1;
      PH_ACTIVE: req_ready = same_slave;
      default:   req_ready = 1'b0;
    endcase
  end

  assign accept = req_valid & req_ready;
  assign finish = (phase_q == PH_ACTIVE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   phase_d = accept ? PH_SETUP : PH_IDLE;
      PH_SETUP:  phase_d = PH_ACTIVE;
      PH_ACTIVE: phase_d = accept ? PH_SETUP : PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/pbm_hold.sv
module pbm_hold #(
  parameter int NUM_SLV = 4,
  parameter int AW      = 8,
  parameter int DW      = 8,
  localparam int SIDW   = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               clear,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic [SIDW-1:0]    req_slave,
  output logic [NUM_SLV-1:0] bus_sel,
  output logic               bus_write,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  output logic [SIDW-1:0]    cur_slave
);

  logic [NUM_SLV-1:0] dec_sel;
  logic [NUM_SLV-1:0] sel_q,   sel_d;
  logic               wr_q,    wr_d;
  logic [AW-1:0]      addr_q,  addr_d;
  logic [DW-1:0]      wdat_q,  wdat_d;
  logic [SIDW-1:0]    idx_q,   idx_d;

  // One-hot decode of the requested slave index.
  for (genvar g = 0; g < NUM_SLV; g++) begin : g_dec
    assign dec_sel[g] = (req_slave == SIDW'(g));
  end

  always_comb begin
    sel_d  = sel_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    idx_d  = idx_q;
    if (load) begin
      sel_d  = dec_sel;
      wr_d   = req_write;
      addr_d = req_addr;
      wdat_d = req_write ? req_wdata : '0;
      idx_d  = req_slave;
    end else if (clear) begin
      sel_d  = '0;
      wr_d   = 1'b0;
      addr_d = '0;
      wdat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      idx_q  <= '0;
    end else if (load || clear) begin
      sel_q  <= sel_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      idx_q  <= idx_d;
    end
  end

  assign bus_sel   = sel_q;
  assign bus_write = wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdat_q;
  assign cur_slave = idx_q;

endmodule

// File: rtl/pbm_resp.sv
module pbm_resp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          finish,
  input  logic          is_write,
  input  logic [DW-1:0] bus_rdata,
  output logic          rsp_valid,
  output logic          rsp_write,
  output logic [DW-1:0] rsp_rdata
);

  logic          vld_q, vld_d;
  logic          wr_q,  wr_d;
  logic [DW-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = finish;
    wr_d  = wr_q;
    dat_d = dat_q;
    if (finish) begin
      wr_d  = is_write;
      dat_d = is_write ? '0 : bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wr_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (finish) begin
        wr_q  <= wr_d;
        dat_q <= dat_d;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_write = wr_q;
  assign rsp_rdata = dat_q;

endmodule

// File: rtl/pbm_master.sv
module pbm_master
  import pbm_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int AW      = 8,
  parameter int DW      = 8,
  localparam int SIDW   = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic [SIDW-1:0]    req_slave,
  output logic [NUM_SLV-1:0] bus_sel,
  output logic               bus_en,
  output logic               bus_write,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  output logic               rsp_valid,
  output logic               rsp_write,
  output logic [DW-1:0]      rsp_rdata
);

  phase_e          phase;
  logic            accept;
  logic            finish;
  logic            same_slave;
  logic            drop;
  logic [SIDW-1:0] cur_slave;

  assign same_slave = (req_slave == cur_slave);
  assign drop       = finish & ~accept;

  pbm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .same_slave (same_slave),
    .phase      (phase),
    .req_ready  (req_ready),
    .accept     (accept),
    .finish     (finish)
  );

  pbm_hold #(
    .NUM_SLV (NUM_SLV),
    .AW      (AW),
    .DW      (DW)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .clear     (drop),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_slave (req_slave),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cur_slave (cur_slave)
  );

  pbm_resp #(
    .DW (DW)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish),
    .is_write  (bus_write),
    .bus_rdata (bus_rdata),
    .rsp_valid (rsp_valid),
    .rsp_write (rsp_write),
    .rsp_rdata (rsp_rdata)
  );

  // Enable is the low bit of the phase code.
  assign bus_en = phase[0];

endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
  parameter int NUM_SLV = 4,
  parameter int AW      = 8,
  parameter int DW      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SLV-1:0] bus_sel,
  input logic               bus_en,
  input logic               bus_write,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_write,
  input logic [DW-1:0]      rsp_rdata
);

  logic in_setup;
  assign in_setup = (bus_sel != '0) && !bus_en;

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  p_en_needs_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (bus_sel != '0));

  p_setup_then_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |=> bus_en);

  p_single_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> !bus_en);

  p_setup_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |=> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_sel)));

  p_no_ready_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |-> !req_ready);

  p_rsp_follows_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> rsp_valid);

  p_rsp_only_after_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !rsp_valid);

  p_read_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_write) |=> (rsp_rdata == $past(bus_rdata) && !rsp_write));

  p_write_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_write) |=> (rsp_write && rsp_rdata == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == '0) |-> (bus_addr == '0 && bus_wdata == '0 && !bus_en));

endmodule

bind pbm_master pbm_checker #(
  .NUM_SLV (NUM_SLV),
  .AW      (AW),
  .DW      (DW)
) u_pbm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_en    (bus_en),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_write (rsp_write),
  .rsp_rdata (rsp_rdata)
);

// File: tb/tb_pbm_master.sv
module tb_pbm_master;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SLV    = 4;
  localparam int AW         = 8;
  localparam int DW         = 8;
  localparam int SIDW       = 2;

  logic               clk;
  logic               rst_n;
  logic               req_valid;
  logic               req_ready;
  logic               req_write;
  logic [AW-1:0]      req_addr;
  logic [DW-1:0]      req_wdata;
  logic [SIDW-1:0]    req_slave;
  logic [NUM_SLV-1:0] bus_sel;
  logic               bus_en;
  logic               bus_write;
  logic [AW-1:0]      bus_addr;
  logic [DW-1:0]      bus_wdata;
  logic [DW-1:0]      bus_rdata;
  logic               rsp_valid;
  logic               rsp_write;
  logic [DW-1:0]      rsp_rdata;

  int checks;
  int errors;

  pbm_master #(.NUM_SLV(NUM_SLV), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_slave(req_slave),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic present(logic w, logic [AW-1:0] a, logic [DW-1:0] d, logic [SIDW-1:0] s);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    req_slave = s;
  endtask

  task automatic withdraw();
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    req_slave = '0;
  endtask

  task automatic check_idle(string tag);
    chk({tag, " sel"},   bus_sel,   0);
    chk({tag, " en"},    bus_en,    0);
    chk({tag, " addr"},  bus_addr,  0);
    chk({tag, " wdata"}, bus_wdata, 0);
  endtask

  task automatic t_reset();
    withdraw();
    bus_rdata = 8'hEE;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    chk("R1 write", bus_write, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid after", rsp_valid, 0);
  endtask

  task automatic t_single(logic w, logic [AW-1:0] a, logic [DW-1:0] d,
                          logic [SIDW-1:0] s, logic [DW-1:0] rd);
    @(negedge clk);
    present(w, a, d, s);
    chk("R5 ready idle", req_ready, 1);
    @(negedge clk);
    withdraw();
    chk("R2 sel", bus_sel, 32'(1) << s);
    chk("R2 en low", bus_en, 0);
    chk("R2 addr", bus_addr, a);
    chk("R2 write", bus_write, w);
    chk("R5 ready setup", req_ready, 0);
    @(negedge clk);
    chk("R3 en active", bus_en, 1);
    chk("R4 addr stable", bus_addr, a);
    chk("R4 sel stable", bus_sel, 32'(1) << s);
    chk("R4 write stable", bus_write, w);
    if (w) chk("R4 wdata", bus_wdata, d);
    bus_rdata = rd;
    @(negedge clk);
    bus_rdata = ~rd;
    chk(w ? "R7 rsp_valid" : "R6 rsp_valid", rsp_valid, 1);
    chk(w ? "R7 rsp_write" : "R6 rsp_write", rsp_write, w);
    chk(w ? "R7 rsp_rdata" : "R6 rsp_rdata", rsp_rdata, w ? 0 : rd);
    check_idle("R9 back to idle");
    @(negedge clk);
    chk(w ? "R7 pulse ends" : "R6 pulse ends", rsp_valid, 0);
    chk("R3 no second en", bus_en, 0);
  endtask

  task automatic t_chain();
    @(negedge clk);
    present(1'b0, 8'h21, 8'h00, 2'd3);
    @(negedge clk);
    present(1'b1, 8'h22, 8'hC3, 2'd3);
    chk("R5 ready low in setup", req_ready, 0);
    @(negedge clk);
    chk("R5 setup request ignored addr", bus_addr, 8'h21);
    chk("R5 setup request ignored write", bus_write, 0);
    chk("R5 ready active same slave", req_ready, 1);
    bus_rdata = 8'h77;
    @(negedge clk);
    withdraw();
    chk("R8 sel held", bus_sel, 4'b1000);
    chk("R8 en low", bus_en, 0);
    chk("R8 new addr", bus_addr, 8'h22);
    chk("R6 first rsp", rsp_rdata, 8'h77);
    chk("R6 first rsp valid", rsp_valid, 1);
    @(negedge clk);
    chk("R8 second active", bus_en, 1);
    chk("R8 second wdata", bus_wdata, 8'hC3);
    chk("R7 no rsp in setup-to-active", rsp_valid, 0);
    @(negedge clk);
    chk("R7 second rsp write", rsp_write, 1);
    chk("R7 second rsp valid", rsp_valid, 1);
    check_idle("R9 after chain");
  endtask

  task automatic t_other_slave();
    @(negedge clk);
    present(1'b0, 8'h40, 8'h00, 2'd1);
    @(negedge clk);
    present(1'b1, 8'h41, 8'h5A, 2'd2);
    @(negedge clk);
    chk("R11 ready low other slave", req_ready, 0);
    bus_rdata = 8'h19;
    @(negedge clk);
    check_idle("R11 idle gap");
    chk("R11 ready in gap", req_ready, 1);
    chk("R6 rsp other", rsp_rdata, 8'h19);
    @(negedge clk);
    withdraw();
    chk("R11 new sel", bus_sel, 4'b0100);
    chk("R11 new addr", bus_addr, 8'h41);
    chk("R11 en low", bus_en, 0);
    @(negedge clk);
    chk("R11 active", bus_en, 1);
    chk("R11 wdata", bus_wdata, 8'h5A);
    @(negedge clk);
    check_idle("R9 after other slave");
    chk("R7 rsp other write", rsp_write, 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_single(1'b0, 8'hA5, 8'h00, 2'd0, 8'h3C);
    t_single(1'b1, 8'hFF, 8'h81, 2'd2, 8'hAA);
    t_single(1'b0, 8'h01, 8'h00, 2'd3, 8'hFF);
    t_chain();
    t_other_slave();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule